// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides an input clock by a programmable integer N and emits one single-cycle pulse per N input cycles, meant for the feedback input of a phase detector. It does not use one wide terminal-count counter. Instead, a small prescaler divides by either P or P+1. Two counters steer it. The swallow count A sets how many prescaler cycles use the long modulus P+1. The main count B sets how many prescaler cycles make up one output period. The result is N = B·P + A.

Software presents a prescaler code, an A value and a B value, then strobes `load`. The block checks the triple at once. A legal triple goes into a holding latch. An illegal one raises `cfg_err` and is dropped. The running counters take the held triple only when the current output period ends. Because of this, reprogramming never produces a shortened or stretched period. If several loads arrive within one period, the last legal one is used.

Top module: `pulse_swallow_divider`

## Requirements
- R1: The prescaler code selects P: code 0 gives P=8, code 1 gives P=16, code 2 gives P=32, code 3 gives P=64.
- R2: With a legal configuration in force, consecutive rising edges of `div_out` are exactly B·P + A input clock cycles apart.
- R3: `div_out` is high for exactly one input clock cycle per period.
- R4: Within each period, the first A prescaler cycles last P+1 input cycles and the remaining B−A cycles last P input cycles. Once the modulus drops to P, it does not return to P+1 before the period ends.
- R5: A load is legal only if B ≥ 1, B ≥ A and A < P (P taken from the code presented with that load). An illegal load sets `cfg_err` in the cycle after the strobe and leaves the division ratio unchanged. `cfg_err` changes only in the cycle after a load.
- R6: A legal load clears `cfg_err` in the cycle after the strobe.
- R7: A legal load made during a period does not change that period's length. The new ratio starts with the following period.
- R8: When two legal loads fall within one period, the later one determines the next period's ratio.
- R9: Synchronous active-low reset drives `div_out` and `cfg_err` low and sets the ratio to the parameter defaults (P=8, A=0, B=1, so N=8).
- R10: The corners A=0 (N=B·P) and A=B=P−1 (every prescaler cycle long) divide correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Strobe: validate and hold the presented configuration |
| pre_sel | input | 2 | Prescaler modulus code (P = 8 << code) |
| swallow_in | input | 6 | Swallow count A |
| main_in | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Last load was rejected as illegal |

## Verification
The bound checker watches properties that hold on every cycle. These are the one-cycle pulse width, the setting and clearing of `cfg_err` in the cycle after a strobe, `cfg_err` holding steady otherwise, the active configuration staying frozen except at a period boundary, and the modulus control never rising again mid-period. Only the bench scenarios can show that the measured period equals B·P + A for each prescaler code, that a rejected or overridden load yields the expected ratio in later periods, and that the period in progress when a load arrives keeps its old length.

// File: rtl/psd_pkg.sv
// Package: shared widths, configuration record and helper functions for the
// pulse-swallow divider. Assumes P = 2**(BASE_LOG2 + code).
package psd_pkg;

    parameter int SEL_W     = 2;
    parameter int A_W       = 6;
    parameter int B_W       = 13;
    parameter int BASE_LOG2 = 3;

    // Prescaler count width: must hold the largest P+1.
    localparam int PC_W = BASE_LOG2 + (1 << SEL_W);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
    } div_cfg_t;

    // Short modulus P for a given code.
    function automatic logic [PC_W-1:0] modulus_p(input logic [SEL_W-1:0] sel);
        return PC_W'(1 << (BASE_LOG2 + int'(sel)));
    endfunction

    // Legality rule for a configuration: B nonzero, B >= A, A < P.
    function automatic logic cfg_ok(input div_cfg_t c);
        return (c.b != '0)
            && (c.b >= B_W'(c.a))
            && (PC_W'(c.a) < modulus_p(c.sel));
    endfunction

endpackage

// File: rtl/psd_cfg_latch.sv
// Holding latch: validates each loaded configuration and keeps the last
// legal one until the counters take it at a period boundary.
// Assumes `take` pulses only in the last cycle of an output period.
module psd_cfg_latch
    import psd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  div_cfg_t cfg_in,
    input  logic     take,
    output div_cfg_t pend_cfg,
    output logic     pend_vld,
    output logic     cfg_err
);

    // Capture legal loads, flag illegal ones, drop pending on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cfg <= '0;
            pend_vld <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            if (take) begin
                pend_vld <= 1'b0;
            end
            if (load) begin
                if (cfg_ok(cfg_in)) begin
                    pend_cfg <= cfg_in;
                    pend_vld <= 1'b1;
                    cfg_err  <= 1'b0;
                end else begin
                    cfg_err  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: divides by P when mod_ctl is low and by P+1 when
// it is high, with tick marking the last input cycle of each prescaler cycle.
// Assumes sel and mod_ctl change only on edges where tick is high.
module psd_prescaler
    import psd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             mod_ctl,
    output logic             tick
);

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] last_val;

    // Terminal count for the modulus currently in force.
    always_comb begin
        last_val = modulus_p(sel) - PC_W'(1) + PC_W'(mod_ctl);
        tick     = (pc == last_val);
    end

    // Free-running count that wraps at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + PC_W'(1);
        end
    end

endmodule

// File: rtl/psd_swallow_ctr.sv
// Swallow (A) and main (B) counters. They count prescaler cycles, hold the
// modulus control high while A has not expired, and mark the period end on
// the last prescaler cycle of B. Both reload together from nxt_cfg.
// Assumes the configuration obeys the legality rule (B >= 1, B >= A).
module psd_swallow_ctr
    import psd_pkg::*;
#(
    parameter logic [A_W-1:0] RST_A = '0,
    parameter logic [B_W-1:0] RST_B = B_W'(1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  div_cfg_t nxt_cfg,
    output logic     mod_ctl,
    output logic     period_end
);

    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;

    // Modulus select and end-of-period decode.
    always_comb begin
        mod_ctl    = (a_rem != '0);
        period_end = tick && (b_rem == B_W'(1));
    end

    // Count down per prescaler cycle, reload both at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rem <= RST_A;
            b_rem <= RST_B;
        end else if (period_end) begin
            a_rem <= nxt_cfg.a;
            b_rem <= nxt_cfg.b;
        end else if (tick) begin
            b_rem <= b_rem - B_W'(1);
            if (a_rem != '0) begin
                a_rem <= a_rem - A_W'(1);
            end
        end
    end

endmodule

// File: rtl/pulse_swallow_divider.sv
// Top: pulse-swallow feedback divider, N = B*P + A. Holds the active
// configuration and switches it only at a period boundary. It registers
// the output pulse. Assumes the reset defaults form a legal configuration.
module pulse_swallow_divider
    import psd_pkg::*;
#(
    parameter logic [SEL_W-1:0] RST_SEL = '0,
    parameter logic [A_W-1:0]   RST_A   = '0,
    parameter logic [B_W-1:0]   RST_B   = B_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic [A_W-1:0]   swallow_in,
    input  logic [B_W-1:0]   main_in,
    output logic             div_out,
    output logic             cfg_err
);

    div_cfg_t cfg_in;
    div_cfg_t pend_cfg;
    div_cfg_t act_cfg;
    div_cfg_t nxt_cfg;
    logic     pend_vld;
    logic     tick;
    logic     mod_ctl;
    logic     period_end;

    // Gather the presented fields into one record.
    always_comb begin
        cfg_in.sel = pre_sel;
        cfg_in.a   = swallow_in;
        cfg_in.b   = main_in;
        nxt_cfg    = pend_vld ? pend_cfg : act_cfg;
    end

    psd_cfg_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_in   (cfg_in),
        .take     (period_end),
        .pend_cfg (pend_cfg),
        .pend_vld (pend_vld),
        .cfg_err  (cfg_err)
    );

    psd_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (act_cfg.sel),
        .mod_ctl (mod_ctl),
        .tick    (tick)
    );

    psd_swallow_ctr #(
        .RST_A (RST_A),
        .RST_B (RST_B)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .nxt_cfg    (nxt_cfg),
        .mod_ctl    (mod_ctl),
        .period_end (period_end)
    );

    // Active configuration: replaced only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg.sel <= RST_SEL;
            act_cfg.a   <= RST_A;
            act_cfg.b   <= RST_B;
        end else if (period_end) begin
            act_cfg <= nxt_cfg;
        end
    end

    // Registered one-cycle output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= 1'b0;
        end else begin
            div_out <= period_end;
        end
    end

endmodule

// File: rtl/psd_checker.sv
// Checker: cycle-by-cycle properties of the pulse-swallow divider, bound
// to the top module. Recomputes load legality from the ports.
module psd_checker
    import psd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [SEL_W-1:0] pre_sel,
    input logic [A_W-1:0]   swallow_in,
    input logic [B_W-1:0]   main_in,
    input logic             div_out,
    input logic             cfg_err,
    input logic             period_end,
    input logic             mod_ctl,
    input div_cfg_t         act_cfg
);

    logic [PC_W-1:0] p_in;
    logic            load_ok;

    // Independent legality decode of the presented fields.
    always_comb begin
        p_in    = PC_W'(8) << pre_sel;
        load_ok = (main_in != '0)
               && ({{(B_W-A_W){1'b0}}, swallow_in} <= main_in)
               && ({{(PC_W-A_W){1'b0}}, swallow_in} < p_in);
    end

    a_r3_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    a_r5_flag_bad_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_ok) |=> cfg_err);

    a_r5_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

    a_r6_clear_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_ok) |=> !cfg_err);

    a_r7_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(act_cfg));

    a_r4_no_modulus_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && !mod_ctl) |=> !mod_ctl);

endmodule

bind pulse_swallow_divider psd_checker u_psd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .pre_sel    (pre_sel),
    .swallow_in (swallow_in),
    .main_in    (main_in),
    .div_out    (div_out),
    .cfg_err    (cfg_err),
    .period_end (period_end),
    .mod_ctl    (mod_ctl),
    .act_cfg    (act_cfg)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  pre_sel = '0;
    logic [5:0]  swallow_in = '0;
    logic [12:0] main_in = '0;
    wire         div_out;
    wire         cfg_err;

    typedef struct {
        int    n;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   last_pulse = -1;
    int   cur_n = 8;
    bit   seen_first = 1'b0;
    bit   prev_div = 1'b0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    pulse_swallow_divider u_pulse_swallow_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .pre_sel    (pre_sel),
        .swallow_in (swallow_in),
        .main_in    (main_in),
        .div_out    (div_out),
        .cfg_err    (cfg_err)
    );

    function automatic int calc_n(int sel, int a, int b);
        return b * (8 << sel) + a;
    endfunction

    task automatic push_exp(int n, string tag, int k);
        for (int i = 0; i < k; i++) exp_q.push_back('{n, tag});
    endtask

    task automatic chk_flag(logic actual, logic expected, string tag);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s cfg_err actual=%0b expected=%0b", tag, actual, expected);
        end
    endtask

    // Monitor: measure pulse spacing and width, pop and compare expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (div_out) begin
                total++;
                if (prev_div) begin
                    bad++;
                    $display("FAIL R3 pulse width actual=2+ expected=1");
                end
                if (last_pulse >= 0 && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    total++;
                    if (cyc - last_pulse != e.n) begin
                        bad++;
                        $display("FAIL %s period actual=%0d expected=%0d",
                                 e.tag, cyc - last_pulse, e.n);
                    end
                end
                last_pulse = cyc;
                seen_first = 1'b1;
            end
            prev_div = div_out;
        end
    end

    // Legal load: current period keeps old N (R7), then k periods of new N.
    task automatic run_cfg(int sel, int a, int b, int k, string tag);
        int n;
        n = calc_n(sel, a, b);
        pre_sel = 2'(sel); swallow_in = 6'(a); main_in = 13'(b); load = 1'b1;
        push_exp(cur_n, "R7", 1);
        push_exp(n, tag, k);
        @(negedge clk);
        load = 1'b0;
        chk_flag(cfg_err, 1'b0, "R6");
        cur_n = n;
        wait (exp_q.size() == 0);
    endtask

    // Illegal load: flag rises, ratio stays (R5).
    task automatic bad_cfg(int sel, int a, int b);
        pre_sel = 2'(sel); swallow_in = 6'(a); main_in = 13'(b); load = 1'b1;
        push_exp(cur_n, "R5", 2);
        @(negedge clk);
        load = 1'b0;
        chk_flag(cfg_err, 1'b1, "R5");
        wait (exp_q.size() == 0);
    endtask

    // Two legal loads in one period: the later one wins (R8).
    task automatic override_cfg(int s1, int a1, int b1, int s2, int a2, int b2, int k);
        int n;
        n = calc_n(s2, a2, b2);
        pre_sel = 2'(s1); swallow_in = 6'(a1); main_in = 13'(b1); load = 1'b1;
        push_exp(cur_n, "R7", 1);
        push_exp(n, "R8", k);
        @(negedge clk);
        pre_sel = 2'(s2); swallow_in = 6'(a2); main_in = 13'(b2);
        @(negedge clk);
        load = 1'b0;
        chk_flag(cfg_err, 1'b0, "R8");
        cur_n = n;
        wait (exp_q.size() == 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        total++;
        if (div_out !== 1'b0) begin
            bad++;
            $display("FAIL R9 div_out in reset actual=%0b expected=0", div_out);
        end
        chk_flag(cfg_err, 1'b0, "R9");
        rst_n = 1'b1;
        wait (seen_first);
        push_exp(8, "R9", 2);
        wait (exp_q.size() == 0);
        run_cfg(0, 3, 5, 3, "R2");
        run_cfg(1, 0, 4, 3, "R10");
        run_cfg(0, 7, 7, 3, "R10");
        run_cfg(2, 20, 30, 2, "R1");
        run_cfg(3, 63, 63, 2, "R1");
        run_cfg(1, 15, 20, 2, "R2");
        bad_cfg(0, 8, 10);
        bad_cfg(1, 5, 3);
        bad_cfg(2, 0, 0);
        run_cfg(0, 1, 2, 3, "R6");
        override_cfg(3, 0, 2, 1, 2, 3, 3);
        run_cfg(1, 1, 2, 3, "R4");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule